// File: doc/BRIEF.md
# DMA Request Line Serial Encoder

This block sits in a peripheral on a low pin count bus. It drives that peripheral's single active-low DMA request line. Device logic hands it commands. Each command names a DMA channel and says whether the request for that channel is being raised or withdrawn. The block turns each command into a short serial message, synchronous to the bus clock. The message starts with one low start clock. The channel number follows, most significant bit first. One activity bit comes last: high raises the request and low abandons an earlier one. After the activity bit the line returns high for one recovery clock.

Commands enter through a valid/ready handshake and wait in a small first-in first-out queue. Requests for several channels can therefore be sent one after another without any arbitration inside the device. When the queue still holds work after a recovery clock, the next start bit follows immediately, so each message takes six clocks. While no message is in progress the line stays high.

Top module: `lpc_dreq_tx`

## Requirements
- R1: After reset, and whenever no message is in progress, `dreq_n` is high, `busy` is low, and `cmd_ready` is high while the queue has room. Asserting reset in the middle of a message returns the line high and empties the queue.
- R2: When a command is accepted while the block is idle, `dreq_n` goes low for exactly one clock as the start bit. This happens in the clock after the accepting edge.
- R3: The three clocks after the start bit carry the channel number, most significant bit first (bit 2, then bit 1, then bit 0), with a 1 driven as high.
- R4: The fifth clock of a message carries the activity bit. It is high when `cmd_act` was 1 (request) and low when it was 0 (abandon).
- R5: The sixth clock of a message drives `dreq_n` high while `busy` stays high. `busy` is high from the start bit through this recovery clock and is low afterwards if nothing is queued.
- R6: If a command is queued when a recovery clock ends, the next start bit follows in the very next clock, giving a six-clock message period. A command accepted during a message also waits for the recovery clock.
- R7: The queue holds four commands. `cmd_ready` is low while it is full, and a `cmd_valid` presented while `cmd_ready` is low is ignored: no message is ever sent for it.
- R8: Messages leave in the order in which their commands were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The queue can take a command this clock |
| cmd_chan | input | 3 | DMA channel number of the offered command |
| cmd_act | input | 1 | 1 to request the channel, 0 to abandon it |
| dreq_n | output | 1 | Serial active-low DMA request line |
| busy | output | 1 | High from the start bit through the recovery clock |

## Verification
A wrong phase counter shows on `dreq_n` within one message. A missing or doubled recovery clock, a start bit that is not low, or a shifted channel field all break the six-clock pattern the bench expects at fixed offsets. A read or write pointer that has slipped in the queue shows up as a wrong channel or a wrong order in the next burst of back-to-back messages, within about six clocks per queued entry. A wrong occupancy count shows up either as `cmd_ready` staying high with four commands waiting, or as an extra message for a command offered while the queue was full.

// File: rtl/lpc_dreq_tx.sv
module lpc_dreq_tx #(
  parameter int CH_W  = 3,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [CH_W-1:0] cmd_chan,
  input  logic            cmd_act,
  output logic            dreq_n,
  output logic            busy
);

  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int GAP  = CH_W + 3;
  localparam int PHW  = $clog2(GAP + 1);

  logic [CH_W:0]  mem [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;
  logic [PHW-1:0] phase;
  logic [CH_W:0]  sh;

  logic push, pop, can_load, in_data;

  assign cmd_ready = (count != CW'(DEPTH));
  assign push      = cmd_valid && cmd_ready;
  assign can_load  = (phase == '0) || (phase == PHW'(GAP));
  assign pop       = can_load && (count != '0);
  assign in_data   = (phase >= PHW'(2)) && (phase <= PHW'(CH_W + 2));

  assign busy   = (phase != '0);
  assign dreq_n = (phase == PHW'(1)) ? 1'b0 : (in_data ? sh[CH_W] : 1'b1);

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {cmd_chan, cmd_act};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      sh    <= '0;
    end else if (can_load) begin
      phase <= pop ? PHW'(1) : '0;
      if (pop) sh <= mem[rd_ptr];
    end else begin
      phase <= phase + 1'b1;
      if (phase >= PHW'(2)) sh <= {sh[CH_W-1:0], 1'b0};
    end
  end

endmodule

module lpc_dreq_tx_chk #(
  parameter int CH_W  = 3,
  parameter int DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic dreq_n,
  input logic busy
);
  localparam int GAP = CH_W + 3;
  int prev, cur;

  always_comb cur = !busy ? 0 : ((prev == 0 || prev == GAP) ? 1 : prev + 1);

  always_ff @(posedge clk)
    if (!rst_n) prev <= 0;
    else        prev <= cur;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dreq_n);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == 1) |-> !dreq_n);
  assert_gap_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == GAP) |-> dreq_n);
  assert_full_then_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == GAP && !cmd_ready) |=> (busy && !dreq_n));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> cmd_ready);
endmodule

bind lpc_dreq_tx lpc_dreq_tx_chk #(.CH_W(CH_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .dreq_n(dreq_n), .busy(busy)
);

// File: tb/lpc_dreq_tx_test.sv
module lpc_dreq_tx_test;
  logic clk = 0, rst_n = 0, cmd_valid = 0, cmd_act = 0;
  logic [2:0] cmd_chan = '0;
  logic cmd_ready, dreq_n, busy;

  lpc_dreq_tx uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
                   .cmd_chan(cmd_chan), .cmd_act(cmd_act), .dreq_n(dreq_n), .busy(busy));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, n = 0;
  logic ln [64], lb [64], lr [64];

  task automatic chk(string req, logic got, logic exp, int idx);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at clock %0d: got %b expected %b", req, idx, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
    ln[n] = dreq_n; lb[n] = busy; lr[n] = cmd_ready; n++;
  endtask

  task automatic drive(logic v, logic [2:0] c, logic a);
    cmd_valid = v; cmd_chan = c; cmd_act = a;
  endtask

  task automatic chk_msg(int b, logic [2:0] c, logic a);
    chk("R2 start", ln[b], 1'b0, b);
    for (int i = 0; i < 3; i++) chk("R3 chan bit", ln[b+1+i], c[2-i], b+1+i);
    chk("R4 act", ln[b+4], a, b+4);
    chk("R5 gap line", ln[b+5], 1'b1, b+5);
    for (int i = 0; i < 6; i++) chk("R5 busy", lb[b+i], 1'b1, b+i);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] bc [5];
    logic       ba [5];
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    n = 0; step();
    chk("R1 idle line", ln[0], 1'b1, 0);
    chk("R1 idle busy", lb[0], 1'b0, 0);
    chk("R1 idle ready", lr[0], 1'b1, 0);

    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 2; a++) begin
        n = 0; step();
        drive(1'b1, 3'(c), 1'(a));
        step();
        drive(1'b0, 3'd0, 1'b0);
        repeat (8) step();
        chk("R2 latency line", ln[1], 1'b1, 1);
        chk("R2 latency busy", lb[1], 1'b0, 1);
        chk_msg(2, 3'(c), 1'(a));
        chk("R5 idle busy", lb[8], 1'b0, 8);
        chk("R1 idle line", ln[8], 1'b1, 8);
      end

    // R6: command arriving during a message waits for the gap
    n = 0; step();
    drive(1'b1, 3'd6, 1'b1); step(); drive(1'b0, 3'd0, 1'b0);
    repeat (4) step();
    drive(1'b1, 3'd1, 1'b0); step(); drive(1'b0, 3'd0, 1'b0);
    repeat (14) step();
    chk_msg(2, 3'd6, 1'b1);
    chk_msg(8, 3'd1, 1'b0);
    chk("R6 idle after", lb[14], 1'b0, 14);

    // R6 R7 R8: burst fills the queue, extra offer ignored
    bc[0] = 3'd5; ba[0] = 1; bc[1] = 3'd2; ba[1] = 0; bc[2] = 3'd7; ba[2] = 1;
    bc[3] = 3'd0; ba[3] = 1; bc[4] = 3'd3; ba[4] = 0;
    n = 0;
    for (int i = 0; i < 5; i++) begin step(); drive(1'b1, bc[i], ba[i]); end
    step(); drive(1'b1, 3'd6, 1'b1);
    step(); step(); drive(1'b0, 3'd0, 1'b0);
    repeat (33) step();
    for (int i = 0; i < 5; i++) chk("R7 ready with room", lr[i], 1'b1, i);
    for (int i = 5; i < 8; i++) chk("R7 ready when full", lr[i], 1'b0, i);
    chk("R7 ready after pop", lr[8], 1'b1, 8);
    for (int j = 0; j < 5; j++) chk_msg(2 + 6*j, bc[j], ba[j]);
    for (int i = 32; i < 40; i++) begin
      chk("R7 ignored offer line", ln[i], 1'b1, i);
      chk("R7 ignored offer busy", lb[i], 1'b0, i);
    end

    // R1: reset mid-message
    n = 0; step();
    drive(1'b1, 3'd0, 1'b1); step(); step(); drive(1'b0, 3'd0, 1'b0);
    step(); rst_n = 0; step(); rst_n = 1;
    repeat (6) step();
    chk("R1 reset line", ln[4], 1'b1, 4);
    chk("R1 reset busy", lb[4], 1'b0, 4);
    for (int i = 5; i < 10; i++) chk("R1 queue emptied", ln[i], 1'b1, i);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule